// File: doc/BRIEF.md
# Overlapping Four-Pulse Sequence Detector

This block watches two single-cycle strobe inputs, `x1_pulse` and `x2_pulse`, on a system clock. It raises a level output when an `x2_pulse` completes the ordered pattern first strobe, second strobe, first strobe, second strobe. Matches may overlap. The output is registered and changes at the same clock edge that samples the completing strobe.

Once high, the output stays high until the next `x1_pulse` arrives. That strobe clears the output and also counts as the third step of a new match, so a following `x2_pulse` raises the output again. Strobes on the second input while the output is high are absorbed without effect. Progress through the pattern is kept in a two-bit register, and the output is kept in a third bit. All three bits are toggle-style flops: each bit flips only when its toggle enable is computed as 1.

Top module: `pulse_seq_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `z_level` becomes 0 and all match progress is cleared. After reset, no output rises until a full four-strobe pattern has been seen.
- R2: `z_level` goes from 0 to 1 only at the edge that samples the `x2_pulse` that completes x1, x2, x1, x2. It is visible in the cycle after that strobe.
- R3: Matches overlap. After a rise, the two strobes x1, x2 are enough to cause another rise.
- R4: `z_level` goes from 1 to 0 only at the edge that samples the first `x1_pulse` after the rise.
- R5: An `x2_pulse` while `z_level` is 1 leaves `z_level` at 1 and leaves match progress unchanged.
- R6: An `x2_pulse` with no partial match keeps the progress empty. An `x1_pulse` after a single x1 keeps the progress at "x1 seen".
- R7: An `x1_pulse` after x1, x2, x1 leaves only "x1 seen" progress. A further x2, x1, x2 is then needed for a rise.
- R8: A cycle with neither strobe, or with both strobes, changes neither `z_level` nor match progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x1_pulse | input | 1 | Single-cycle strobe for the first pattern symbol |
| x2_pulse | input | 1 | Single-cycle strobe for the second pattern symbol |
| z_level | output | 1 | Registered detector level |

## Verification
The match progress is not visible at the ports. A wrong progress value therefore shows up only as a rise of `z_level` that comes too early, too late or not at all. This appears at the first completing `x2_pulse` after the state goes wrong, which is at most three strobes later. A wrong clear or hold of the level shows in the very next cycle. The bench compares `z_level` with a reference model after every strobe. Long random runs of strobes mixed with idle and double cycles reach every state path.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int PROG_W = 2;
  localparam int BITS_W = PROG_W + 1;

  typedef enum logic [PROG_W-1:0] {
    PR_NONE  = 2'b00,
    PR_A     = 2'b01,
    PR_AB    = 2'b11,
    PR_ABA   = 2'b10
  } prog_t;
endpackage

// File: rtl/pseq_next.sv
module pseq_next
  import pseq_pkg::*;
(
  input  logic [PROG_W-1:0] prog_cur,
  input  logic              z_cur,
  input  logic              s1,
  input  logic              s2,
  output logic [BITS_W-1:0] tog
);
  prog_t p_cur;
  prog_t p_nxt;
  logic  z_nxt;
  logic  only1;
  logic  only2;

  assign p_cur = prog_t'(prog_cur);
  assign only1 = s1 & ~s2;
  assign only2 = s2 & ~s1;

  always_comb begin
    p_nxt = p_cur;
    z_nxt = z_cur;
    if (z_cur) begin
      if (only1) begin
        z_nxt = 1'b0;
        p_nxt = PR_ABA;
      end
    end else if (only1) begin
      unique case (p_cur)
        PR_AB:   p_nxt = PR_ABA;
        default: p_nxt = PR_A;
      endcase
    end else if (only2) begin
      unique case (p_cur)
        PR_A:    p_nxt = PR_AB;
        PR_ABA: begin
          p_nxt = PR_AB;
          z_nxt = 1'b1;
        end
        default: p_nxt = PR_NONE;
      endcase
    end
  end

  assign tog = {z_nxt ^ z_cur, p_nxt ^ p_cur};
endmodule

// File: rtl/pseq_tbank.sv
module pseq_tbank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] t,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)       bit_q <= 1'b0;
      else if (t[i]) bit_q <= ~bit_q;
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/pulse_seq_detect.sv
module pulse_seq_detect
  import pseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x1_pulse,
  input  logic x2_pulse,
  output logic z_level
);
  logic [BITS_W-1:0] bits_q;
  logic [BITS_W-1:0] bits_t;
  logic [PROG_W-1:0] prog_q;

  assign prog_q  = bits_q[PROG_W-1:0];
  assign z_level = bits_q[PROG_W];

  pseq_next u_next (
    .prog_cur (prog_q),
    .z_cur    (bits_q[PROG_W]),
    .s1       (x1_pulse),
    .s2       (x2_pulse),
    .tog      (bits_t)
  );

  pseq_tbank #(.W(BITS_W)) u_bank (
    .clk (clk),
    .rst (rst),
    .t   (bits_t),
    .q   (bits_q)
  );
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker
  import pseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              x1_pulse,
  input logic              x2_pulse,
  input logic              z_level,
  input logic [PROG_W-1:0] prog_q
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!z_level && prog_q == PR_NONE));
  a_r2_rise_on_x2: assert property (@(posedge clk) disable iff (rst)
    $rose(z_level) |-> $past(x2_pulse && !x1_pulse));
  a_r4_fall_on_x1: assert property (@(posedge clk) disable iff (rst)
    (z_level && x1_pulse && !x2_pulse) |=> !z_level);
  a_r3_clear_counts: assert property (@(posedge clk) disable iff (rst)
    (z_level && x1_pulse && !x2_pulse) |=> prog_q == PR_ABA);
  a_r5_hold_on_x2: assert property (@(posedge clk) disable iff (rst)
    (z_level && x2_pulse && !x1_pulse) |=> (z_level && $stable(prog_q)));
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !(x1_pulse ^ x2_pulse) |=> ($stable(z_level) && $stable(prog_q)));
  a_r2_high_means_ab: assert property (@(posedge clk) disable iff (rst)
    z_level |-> prog_q == PR_AB);
endmodule

bind pulse_seq_detect pseq_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .x1_pulse (x1_pulse),
  .x2_pulse (x2_pulse),
  .z_level  (z_level),
  .prog_q   (prog_q)
);

// File: tb/sim_pulse_seq_detect.sv
module sim_pulse_seq_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x1 = 1'b0;
  logic x2 = 1'b0;
  logic z;
  int   n_chk = 0;
  int   n_bad = 0;
  int   m_prog = 0;
  logic m_z = 1'b0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pulse_seq_detect u0 (.clk(clk), .rst(rst), .x1_pulse(x1), .x2_pulse(x2), .z_level(z));

  // reference model: progress 0 none, 1 x1, 2 x1x2, 3 x1x2x1
  task automatic model(input logic a, input logic b);
    if (a == b) return;
    if (m_z) begin
      if (a) begin m_z = 1'b0; m_prog = 3; end
    end else if (a) begin
      m_prog = (m_prog == 2) ? 3 : 1;
    end else begin
      if (m_prog == 1) m_prog = 2;
      else if (m_prog == 3) begin m_prog = 2; m_z = 1'b1; end
      else m_prog = 0;
    end
  endtask

  task automatic check(input string tag, input logic exp);
    n_chk++;
    if (z !== exp) begin
      n_bad++;
      $display("FAIL %s: z_level=%b expected=%b at %0t", tag, z, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic b, input string tag);
    x1 = a; x2 = b;
    model(a, b);
    @(negedge clk);
    x1 = 1'b0; x2 = 1'b0;
    check(tag, m_z);
  endtask

  task automatic do_reset();
    rst = 1'b1; x1 = 1'b0; x2 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_prog = 0; m_z = 1'b0;
    check("R1 reset", 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R1: reset mid-pattern clears progress
    step(1,0,"R1 pre"); step(0,1,"R1 pre"); step(1,0,"R1 pre");
    do_reset();
    step(0,1,"R1 no rise after reset"); check("R1", 1'b0);
    // R6: leading x2 and repeated x1
    step(0,1,"R6 x2 idle"); step(1,0,"R6"); step(1,0,"R6 x1 repeat");
    step(0,1,"R6"); step(1,0,"R6"); step(0,1,"R2 rise"); check("R2 rise", 1'b1);
    // R5: x2 while high
    step(0,1,"R5 hold"); step(0,1,"R5 hold");
    // R8: idle and double strobes while high
    step(0,0,"R8 idle"); step(1,1,"R8 both");
    // R4 / R3: clear then overlap rise
    step(1,0,"R4 fall"); check("R4 fall", 1'b0);
    step(0,1,"R3 overlap rise"); check("R3", 1'b1);
    // R7: x1 after x1x2x1
    step(1,0,"R7"); step(1,0,"R7 back to A"); step(0,1,"R7 no rise");
    step(1,0,"R7"); step(0,1,"R7 rise"); check("R7", 1'b1);
    // R8: double strobe while low in x1x2x1 state
    step(1,0,"R8"); step(1,1,"R8 both low"); step(0,0,"R8 idle");
    step(0,1,"R8 progress kept"); check("R8", 1'b1);
    // random run
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (i % 997 == 500) do_reset();
      if (r < 8)       step(1,0,"R2-R5 random");
      else if (r < 16) step(0,1,"R2-R5 random");
      else if (r < 18) step(0,0,"R8 random idle");
      else             step(1,1,"R8 random both");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule